// File: doc/BRIEF.md
# Page Translation Buffer with Write Guard

This block translates the virtual addresses of one processor access port into physical addresses. It holds a small, fully associative set of page mappings. An address is split into a 20-bit virtual page number and a 12-bit offset inside a 4 KB page. The page number is compared against every stored mapping in parallel. On a match, the block puts out the stored physical page number joined to the unchanged offset. If no mapping matches, it raises a miss exception. If the access is a write and the matching mapping does not allow writes, it raises a protection exception.

Each mapping also carries a modified flag. The flag is set by the first write that the block lets through to that page. A fault handler running in supervisor mode installs new mappings through a separate fill port. The fill goes to the lowest free slot when one exists. When every slot is in use, a rotating pointer picks the slot to overwrite. A single flush input discards every mapping at once.

Top module: `xlat_guard_tlb`

## Requirements
- R1: On a hit, `rsp_ok` is 1 and `rsp_paddr` equals the stored 20-bit physical page number in bits 31:12, with `req_vaddr[11:0]` copied unchanged into bits 11:0.
- R2: When no valid slot holds the page number `req_vaddr[31:12]`, `rsp_miss_exc` is 1, `rsp_ok` is 0 and `rsp_paddr` is all zeros.
- R3: A write (`req_write`=1) that hits a slot whose writable flag is 0 raises `rsp_prot_exc`, keeps `rsp_ok` at 0 and `rsp_paddr` at zero, and leaves that slot's modified flag unchanged.
- R4: Translation is combinational. The result of a request appears in the same clock cycle as the request, with no register on the lookup path.
- R5: A write hit on a writable slot sets that slot's modified flag at the next clock edge. `rsp_dirty` shows the flag of the matched slot as it stood before the access. Read hits never set the flag.
- R6: A fill (`fill_en`=1) with `priv_super`=0 changes no slot.
- R7: A supervisor fill writes the lowest-numbered invalid slot and clears its modified flag. When all slots are valid, it overwrites the slot at a rotating pointer. The pointer starts at 0 after reset or flush, and moves to the next slot, wrapping at the top, after each such overwrite.
- R8: Reset and `flush_all` each invalidate every slot in one cycle, so that any following lookup misses. A flush takes priority over a fill in the same cycle.
- R9: When several valid slots hold the same page number, the lowest-numbered slot supplies the translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every slot |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | Access is a write |
| req_vaddr | input | 32 | Virtual address |
| rsp_ok | output | 1 | Translation granted |
| rsp_paddr | output | 32 | Physical address, zero unless granted |
| rsp_miss_exc | output | 1 | No mapping for the page |
| rsp_prot_exc | output | 1 | Write to a read-only page |
| rsp_dirty | output | 1 | Modified flag of the matched slot |
| fill_en | input | 1 | Install a mapping |
| priv_super | input | 1 | Requester is in supervisor mode |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_writable | input | 1 | Page allows writes |

## Verification
The bench builds the block with its default parameters: 16 slots, 32-bit addresses and 4 KB pages. This is small enough to fill every slot in a few dozen cycles, so the overwrite path and the wrap of the rotating pointer can be reached. The wide page and offset fields let distinct bit patterns in the upper and lower address bits show whether the two are joined correctly. Duplicate mappings and read-only pages are installed on purpose, so that match priority and the write guard can be observed at the response ports.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

   // Outcome of one lookup
   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_OK   = 2'd1,
      XS_MISS = 2'd2,
      XS_PROT = 2'd3
   } xlat_status_e;

endpackage

// File: rtl/xlat_tlb_match.sv
module xlat_tlb_match #(
   parameter int SLOTS = 16,
   parameter int KEY_W = 20,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic [SLOTS-1:0]            slot_vld,
   input  logic [SLOTS-1:0][KEY_W-1:0] slot_key,
   input  logic [KEY_W-1:0]            key,
   output logic                        hit,
   output logic [IDX_W-1:0]            hit_idx
);

   // Scan from the top down so that the lowest match is written last and wins.
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (slot_vld[i] && (slot_key[i] == key)) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   // R9
   always_comb begin
      sel_valid_chk : assert (!hit || (slot_vld[hit_idx] && slot_key[hit_idx] == key))
         else $error("selected slot does not match key");
   end

endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
   parameter int SLOTS = 16,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             take,
   input  logic [SLOTS-1:0] slot_vld,
   output logic [IDX_W-1:0] victim_idx
);

   logic             any_free;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_q;

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!slot_vld[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign victim_idx = any_free ? free_idx : rr_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         rr_q <= '0;
      end else if (take && !any_free) begin
         rr_q <= (rr_q == IDX_W'(SLOTS - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   // R7
   always_comb begin
      free_first_chk : assert (!any_free || !slot_vld[victim_idx])
         else $error("victim is valid although a free slot exists");
   end

   // R7
   rr_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !flush) |=> $stable(rr_q))
      else $error("rotating pointer moved without a fill");

endmodule

// File: rtl/xlat_guard_tlb.sv
module xlat_guard_tlb #(
   parameter int SLOTS  = 16,
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int PAGE_W = 12,
   localparam int VPN_W = VA_W - PAGE_W,
   localparam int PPN_W = PA_W - PAGE_W,
   localparam int IDX_W = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_all,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [VA_W-1:0]  req_vaddr,
   output logic             rsp_ok,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_miss_exc,
   output logic             rsp_prot_exc,
   output logic             rsp_dirty,
   input  logic             fill_en,
   input  logic             priv_super,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  logic             fill_writable
);
   import xlat_tlb_pkg::*;

   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (PAGE_W < 1 || PAGE_W >= VA_W || PAGE_W >= PA_W) begin : g_bad_page
      $error("PAGE_W must be below both address widths");
   end

   logic [SLOTS-1:0]            vld_q;
   logic [SLOTS-1:0]            wr_q;
   logic [SLOTS-1:0]            dirty_q;
   logic [SLOTS-1:0][VPN_W-1:0] tag_q;
   logic [SLOTS-1:0][PPN_W-1:0] ppn_q;

   logic             hit;
   logic [IDX_W-1:0] hit_idx;
   logic [IDX_W-1:0] victim_idx;
   logic             fill_go;
   logic             mark_dirty;
   xlat_status_e     status;

   assign fill_go = fill_en && priv_super && !flush_all;

   xlat_tlb_match #(.SLOTS(SLOTS), .KEY_W(VPN_W)) u_match (
      .slot_vld (vld_q),
      .slot_key (tag_q),
      .key      (req_vaddr[VA_W-1:PAGE_W]),
      .hit      (hit),
      .hit_idx  (hit_idx)
   );

   xlat_tlb_victim #(.SLOTS(SLOTS)) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush_all),
      .take       (fill_go),
      .slot_vld   (vld_q),
      .victim_idx (victim_idx)
   );

   always_comb begin
      if (!req_valid)                      status = XS_IDLE;
      else if (!hit)                       status = XS_MISS;
      else if (req_write && !wr_q[hit_idx]) status = XS_PROT;
      else                                 status = XS_OK;
   end

   assign rsp_ok       = (status == XS_OK);
   assign rsp_miss_exc = (status == XS_MISS);
   assign rsp_prot_exc = (status == XS_PROT);
   assign rsp_paddr    = rsp_ok ? {ppn_q[hit_idx], req_vaddr[PAGE_W-1:0]} : '0;
   assign rsp_dirty    = req_valid && hit && dirty_q[hit_idx];
   assign mark_dirty   = rsp_ok && req_write;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[s]   <= 1'b0;
            dirty_q[s] <= 1'b0;
         end else if (flush_all) begin
            vld_q[s]   <= 1'b0;
         end else if (fill_go && victim_idx == IDX_W'(s)) begin
            vld_q[s]   <= 1'b1;
            dirty_q[s] <= 1'b0;
         end else if (mark_dirty && hit_idx == IDX_W'(s)) begin
            dirty_q[s] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (fill_go && victim_idx == IDX_W'(s)) begin
            tag_q[s] <= fill_vpn;
            ppn_q[s] <= fill_ppn;
            wr_q[s]  <= fill_writable;
         end
      end
   end

   // R2
   outcome_excl_chk : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_ok, rsp_miss_exc, rsp_prot_exc}))
      else $error("more than one outcome flagged");

   // R8
   flush_clears_chk : assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (vld_q == '0))
      else $error("slots survive a flush");

   // R6
   user_fill_ignored_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !priv_super && !flush_all) |=> $stable(vld_q))
      else $error("user-mode fill changed the slot set");

   // R5
   dirty_set_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_ok && req_write && !flush_all && !fill_go) |=> dirty_q[$past(hit_idx)])
      else $error("granted write left modified flag clear");

   // R3
   prot_no_dirty_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_prot_exc && !flush_all && !fill_go) |=> $stable(dirty_q))
      else $error("denied write changed a modified flag");

endmodule

// File: tb/tb_xlat_guard_tlb.sv
module tb_xlat_guard_tlb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_all = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        rsp_ok, rsp_miss_exc, rsp_prot_exc, rsp_dirty;
   logic [31:0] rsp_paddr;
   logic        fill_en = 1'b0;
   logic        priv_super = 1'b1;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic        fill_writable = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   xlat_guard_tlb dut (
      .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
      .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
      .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr), .rsp_miss_exc(rsp_miss_exc),
      .rsp_prot_exc(rsp_prot_exc), .rsp_dirty(rsp_dirty),
      .fill_en(fill_en), .priv_super(priv_super), .fill_vpn(fill_vpn),
      .fill_ppn(fill_ppn), .fill_writable(fill_writable)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                       input logic wr, input logic sup);
      @(negedge clk);
      fill_en = 1'b1; priv_super = sup;
      fill_vpn = vpn; fill_ppn = ppn; fill_writable = wr;
      @(negedge clk);
      fill_en = 1'b0; priv_super = 1'b1;
   endtask

   task automatic flush();
      @(negedge clk);
      flush_all = 1'b1;
      @(negedge clk);
      flush_all = 1'b0;
   endtask

   // Drive a request in the low phase, sample 1 ns later, then let one edge pass.
   task automatic look(input logic [31:0] va, input logic wr,
                       output logic [31:0] pa, output logic [3:0] flags);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_vaddr = va;
      #1;
      pa = rsp_paddr;
      flags = {rsp_ok, rsp_miss_exc, rsp_prot_exc, rsp_dirty};
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // flags = {ok, miss, prot, dirty}
   task automatic t_reset();
      logic [31:0] pa; logic [3:0] f;
      look(32'h0000_0000, 1'b0, pa, f);
      check("R8 reset leaves all slots invalid", {28'd0, f}, 32'b0100);
      check("R2 miss gives zero address", pa, 32'h0);
   endtask

   task automatic t_translate();
      logic [31:0] pa; logic [3:0] f;
      fill(20'h12345, 20'hABCDE, 1'b1, 1'b1);
      look(32'h1234_5678, 1'b0, pa, f);
      check("R1 R4 read hit same-cycle address", pa, 32'hABCD_E678);
      check("R1 read hit flags", {28'd0, f}, 32'b1000);
      look(32'h1234_5FFF, 1'b0, pa, f);
      check("R1 offset passes unchanged", pa, 32'hABCD_EFFF);
   endtask

   task automatic t_miss();
      logic [31:0] pa; logic [3:0] f;
      look(32'h5555_5000, 1'b1, pa, f);
      check("R2 unmapped write misses", {28'd0, f}, 32'b0100);
      check("R2 unmapped address zero", pa, 32'h0);
   endtask

   task automatic t_protect();
      logic [31:0] pa; logic [3:0] f;
      fill(20'h00777, 20'h00111, 1'b0, 1'b1);
      look(32'h0077_7010, 1'b1, pa, f);
      check("R3 write to read-only raises protection", {28'd0, f}, 32'b0010);
      check("R3 denied write has zero address", pa, 32'h0);
      look(32'h0077_7010, 1'b0, pa, f);
      check("R3 read of read-only page ok, flag still clear", {28'd0, f}, 32'b1000);
      check("R3 read of read-only page address", pa, 32'h0011_1010);
   endtask

   task automatic t_dirty();
      logic [31:0] pa; logic [3:0] f;
      look(32'h1234_5004, 1'b1, pa, f);
      check("R5 first write granted, flag shown clear", {28'd0, f}, 32'b1000);
      look(32'h1234_5008, 1'b0, pa, f);
      check("R5 flag set after granted write", {28'd0, f}, 32'b1001);
      look(32'h0077_7000, 1'b0, pa, f);
      look(32'h0077_7000, 1'b0, pa, f);
      check("R5 read hits leave flag clear", {28'd0, f}, 32'b1000);
   endtask

   task automatic t_user_fill();
      logic [31:0] pa; logic [3:0] f;
      fill(20'h0BEEF, 20'h0CAFE, 1'b1, 1'b0);
      look(32'h0BEE_F000, 1'b0, pa, f);
      check("R6 user-mode fill ignored", {28'd0, f}, 32'b0100);
   endtask

   task automatic t_flush();
      logic [31:0] pa; logic [3:0] f;
      flush();
      look(32'h1234_5678, 1'b0, pa, f);
      check("R8 flush removes mapping", {28'd0, f}, 32'b0100);
      look(32'h0077_7000, 1'b0, pa, f);
      check("R8 flush removes second mapping", {28'd0, f}, 32'b0100);
   endtask

   task automatic t_dup();
      logic [31:0] pa; logic [3:0] f;
      fill(20'h00042, 20'h00A00, 1'b1, 1'b1);
      fill(20'h00042, 20'h00B00, 1'b1, 1'b1);
      look(32'h0004_2123, 1'b0, pa, f);
      check("R9 lowest duplicate slot wins", pa, 32'h00A0_0123);
      flush();
   endtask

   task automatic t_rotate();
      logic [31:0] pa; logic [3:0] f;
      for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1'b1, 1'b1);
      look(32'h0010_F000, 1'b0, pa, f);
      check("R7 sixteenth fill in last free slot", pa, 32'h0020_F000);
      fill(20'h00999, 20'h00333, 1'b1, 1'b1);
      look(32'h0010_0000, 1'b0, pa, f);
      check("R7 full table overwrites slot 0 first", {28'd0, f}, 32'b0100);
      look(32'h0099_9000, 1'b0, pa, f);
      check("R7 new mapping present", pa, 32'h0033_3000);
      fill(20'h00998, 20'h00334, 1'b1, 1'b1);
      look(32'h0010_1000, 1'b0, pa, f);
      check("R7 pointer advances to slot 1", {28'd0, f}, 32'b0100);
      look(32'h0010_2000, 1'b0, pa, f);
      check("R7 slot 2 kept", pa, 32'h0020_2000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_translate();
      t_miss();
      t_protect();
      t_dirty();
      t_user_fill();
      t_flush();
      t_dup();
      t_rotate();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule